// File: doc/BRIEF.md
# Monitor Channel Handshake Endpoint

This block terminates one monitor channel of a frame-based serial control interface and watches the command/indicate (C/I) code on the same link. Bit timing and serialisation are handled elsewhere. Once per frame, the framer raises `frame_i` for a single clock cycle. On that cycle it presents the received monitor byte, the remote handshake bits and the 4-bit C/I code. The block uses them to update its own outgoing monitor byte and handshake bits.

Receive direction:
- The remote side marks a byte as valid with its transmit-handshake bit.
- The endpoint accepts the byte only when the same value appears in two consecutive frames.
- It acknowledges each accepted byte by toggling its own receive-handshake bit.
- If the second sighting of a byte differs from the first, the endpoint sends an abort back to the sender.

Transmit direction:
- The host loads one byte at a time.
- The byte is offered until the remote side toggles its acknowledge bit or aborts.

Every event is recorded in an 8-bit status register, and reading that register clears it.

Top module: `gci_mon_ep`

## Requirements
- R1: `status_o` holds: bit5 C/I change, bit4 end of message, bit3 transmit abort, bit2 receive byte ready, bit1 remote abort, bit0 transmit ready. Bits 7:6 always read 0. After reset `status_o` is 0x01 and `rx_data_o`, `ci_o`, `tx_byte_o`, `tx_mx_o`, `tx_mr_o`, `tx_abt_o` and `irq_o`... are 0, except `irq_o`, which is 1.
- R2: A frame whose `rx_ci_i` differs from `ci_o` loads `ci_o` with the new code and sets bit5. A frame with an equal code sets nothing.
- R3: A byte is accepted when two consecutive frames have `rx_mx_i`=1 and carry the same byte. On acceptance:
  - `rx_data_o` takes the byte.
  - Bit2 is set.
  - `tx_mr_o` toggles.
  
  The one frame that follows an acceptance is ignored. The next sighting after that frame counts as a first sighting.
- R4: Suppose the frame after a first sighting has `rx_mx_i`=1 but a different byte. Then bit3 is set and `tx_abt_o` is 1 until the next frame. `rx_data_o` and `tx_mr_o` stay unchanged, and that frame does not count as a first sighting.
- R5: Once at least one byte has been accepted, two consecutive frames with `rx_mx_i`=0 set bit4. Bit4 is not set again until another byte has been accepted. A mismatch abort also closes the message.
- R6: A frame with `rx_abt_i`=1 sets bit1. If a transmit byte is pending, that frame also drops it, so `tx_mx_o` goes to 0, and sets bit0.
- R7: With `tx_mx_o`=0, `wr_i` loads `wdata_i` into `tx_byte_o`, sets `tx_mx_o` and clears bit0. `wr_i` while `tx_mx_o`=1 is ignored.
- R8: A frame with `tx_mx_o`=1 and `rx_mr_i` different from its value in the previous frame (0 before the first frame) acknowledges the pending byte. `tx_mx_o` goes to 0 and bit0 is set.
- R9: `rd_i` clears all status bits at the next clock edge, but a bit set on that same edge stays set. `irq_o` is 1 whenever any status bit is set.
- R10: `rx_data_o`, `ci_o`, `tx_mr_o` and `tx_abt_o` change only on a clock edge where `frame_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per frame |
| rx_byte_i | input | 8 | Received monitor byte |
| rx_mx_i | input | 1 | Remote transmit handshake (byte valid) |
| rx_mr_i | input | 1 | Remote acknowledge, toggles per byte |
| rx_abt_i | input | 1 | Remote abort indication |
| rx_ci_i | input | 4 | Received C/I code |
| rd_i | input | 1 | Host reads status (clear on read) |
| wr_i | input | 1 | Host loads transmit byte |
| wdata_i | input | 8 | Transmit byte from host |
| status_o | output | 8 | Status register |
| irq_o | output | 1 | Any status bit set |
| rx_data_o | output | 8 | Last accepted receive byte |
| ci_o | output | 4 | Stored C/I code |
| tx_byte_o | output | 8 | Outgoing monitor byte |
| tx_mx_o | output | 1 | Local transmit handshake (byte pending) |
| tx_mr_o | output | 1 | Local acknowledge, toggles per accepted byte |
| tx_abt_o | output | 1 | Abort sent to remote sender |

## Verification
Directed sequences check the following behaviours:
- A repeated byte is accepted, which tells acceptance apart from a single sighting.
- The frame after acceptance is skipped, which tells whether that frame is really ignored.
- A changed second byte produces an abort, which tells an abort apart from a late acceptance.
- Idle pairs produce end of message only after a byte, which tells a real message end apart from idle after reset.

On the transmit side, directed tests cover an acknowledge toggle, a remote abort and a write into a full buffer. Another directed test sets a flag in the same cycle as a read, showing that the set takes priority over the clear.

Random frames then draw bytes from two values, so that matches and mismatches occur in similar numbers. They also mix C/I codes, aborts, reads and writes, so that events interleave in orders the directed cases do not reach.

// File: rtl/gci_mon_pkg.sv
`timescale 1ns/1ps
package gci_mon_pkg;
  localparam int STAT_W = 8;
  localparam int B_XMR = 0;
  localparam int B_RAB = 1;
  localparam int B_RMR = 2;
  localparam int B_XAB = 3;
  localparam int B_EOM = 4;
  localparam int B_CIC = 5;
  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << B_XMR;

  typedef enum logic [1:0] {RX_IDLE, RX_CAND, RX_SKIP} rx_st_e;
endpackage

// File: rtl/gci_mon_rx.sv
`timescale 1ns/1ps
module gci_mon_rx
  import gci_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              mx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_o,
  output logic              abt_o,
  output logic              evt_acc_o,
  output logic              evt_mis_o,
  output logic              evt_eom_o
);
  rx_st_e            st_q, st_d;
  logic [DATA_W-1:0] cand_q, cand_d, data_q, data_d;
  logic              ack_q, ack_d, abt_q, abt_d;
  logic              prev_q, prev_d, open_q, open_d;

  always_comb begin
    st_d      = st_q;
    cand_d    = cand_q;
    data_d    = data_q;
    ack_d     = ack_q;
    abt_d     = abt_q;
    prev_d    = prev_q;
    open_d    = open_q;
    evt_acc_o = 1'b0;
    evt_mis_o = 1'b0;
    evt_eom_o = 1'b0;
    if (frame_i) begin
      prev_d = mx_i;
      abt_d  = 1'b0;
      if (!mx_i) begin
        st_d = RX_IDLE;
        if (!prev_q && open_q) begin
          evt_eom_o = 1'b1;
          open_d    = 1'b0;
        end
      end else begin
        unique case (st_q)
          RX_IDLE: begin
            st_d   = RX_CAND;
            cand_d = byte_i;
          end
          RX_CAND: begin
            if (byte_i == cand_q) begin
              evt_acc_o = 1'b1;
              data_d    = byte_i;
              ack_d     = ~ack_q;
              open_d    = 1'b1;
              st_d      = RX_SKIP;
            end else begin
              evt_mis_o = 1'b1;
              abt_d     = 1'b1;
              open_d    = 1'b0;
              st_d      = RX_IDLE;
            end
          end
          default: st_d = RX_IDLE;  // frame after acceptance ignored
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cand_q <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
      abt_q  <= 1'b0;
      prev_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      data_q <= data_d;
      ack_q  <= ack_d;
      abt_q  <= abt_d;
      prev_q <= prev_d;
      open_q <= open_d;
    end
  end

  assign data_o = data_q;
  assign ack_o  = ack_q;
  assign abt_o  = abt_q;
endmodule

// File: rtl/gci_mon_tx.sv
`timescale 1ns/1ps
module gci_mon_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mr_i,
  input  logic              rabt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              mx_o,
  output logic              wr_ok_o,
  output logic              evt_rdy_o,
  output logic              evt_rab_o
);
  logic              full_q, full_d, seen_q, seen_d;
  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    full_d    = full_q;
    byte_d    = byte_q;
    seen_d    = seen_q;
    evt_rdy_o = 1'b0;
    evt_rab_o = 1'b0;
    wr_ok_o   = wr_i && !full_q;
    if (frame_i) begin
      seen_d = mr_i;
      if (rabt_i) begin
        evt_rab_o = 1'b1;
        if (full_q) begin
          full_d    = 1'b0;
          evt_rdy_o = 1'b1;
        end
      end else if (full_q && (mr_i != seen_q)) begin
        full_d    = 1'b0;
        evt_rdy_o = 1'b1;
      end
    end
    if (wr_ok_o) begin
      full_d = 1'b1;
      byte_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      byte_q <= '0;
      seen_q <= 1'b0;
    end else begin
      full_q <= full_d;
      byte_q <= byte_d;
      seen_q <= seen_d;
    end
  end

  assign byte_o = byte_q;
  assign mx_o   = full_q;
endmodule

// File: rtl/gci_mon_ci.sv
`timescale 1ns/1ps
module gci_mon_ci #(
  parameter int CI_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic [CI_W-1:0] ci_i,
  output logic [CI_W-1:0] ci_o,
  output logic            evt_o
);
  logic [CI_W-1:0] ci_q;

  assign evt_o = frame_i && (ci_i != ci_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ci_q <= '0;
    else if (evt_o) ci_q <= ci_i;
  end

  assign ci_o = ci_q;
endmodule

// File: rtl/gci_mon_stat.sv
`timescale 1ns/1ps
module gci_mon_stat
  import gci_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= STAT_RST;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gci_mon_ep.sv
`timescale 1ns/1ps
module gci_mon_ep
  import gci_mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CI_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_mx_i,
  input  logic              rx_mr_i,
  input  logic              rx_abt_i,
  input  logic [CI_W-1:0]   rx_ci_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [CI_W-1:0]   ci_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_mx_o,
  output logic              tx_mr_o,
  output logic              tx_abt_o
);
  logic              evt_acc, evt_mis, evt_eom, evt_rdy, evt_rab, evt_cic, wr_ok;
  logic [STAT_W-1:0] set_v, clr_v;

  gci_mon_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .byte_i    (rx_byte_i),
    .mx_i      (rx_mx_i),
    .data_o    (rx_data_o),
    .ack_o     (tx_mr_o),
    .abt_o     (tx_abt_o),
    .evt_acc_o (evt_acc),
    .evt_mis_o (evt_mis),
    .evt_eom_o (evt_eom)
  );

  gci_mon_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .mr_i      (rx_mr_i),
    .rabt_i    (rx_abt_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .byte_o    (tx_byte_o),
    .mx_o      (tx_mx_o),
    .wr_ok_o   (wr_ok),
    .evt_rdy_o (evt_rdy),
    .evt_rab_o (evt_rab)
  );

  gci_mon_ci #(.CI_W(CI_W)) u_ci (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .ci_i    (rx_ci_i),
    .ci_o    (ci_o),
    .evt_o   (evt_cic)
  );

  always_comb begin
    set_v        = '0;
    set_v[B_XMR] = evt_rdy;
    set_v[B_RAB] = evt_rab;
    set_v[B_RMR] = evt_acc;
    set_v[B_XAB] = evt_mis;
    set_v[B_EOM] = evt_eom;
    set_v[B_CIC] = evt_cic;
    clr_v        = rd_i ? '1 : '0;
    clr_v[B_XMR] = rd_i | wr_ok;
  end

  gci_mon_stat u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .stat_o (status_o)
  );

  assign irq_o = |status_o;
endmodule

// File: rtl/gci_mon_ep_chk.sv
`timescale 1ns/1ps
module gci_mon_ep_chk #(
  parameter int DATA_W = 8,
  parameter int CI_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              rx_abt_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        status_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [CI_W-1:0]   ci_o,
  input logic [DATA_W-1:0] tx_byte_o,
  input logic              tx_mx_o,
  input logic              tx_mr_o,
  input logic              tx_abt_o
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00);  // R1
  AST_CI_CHANGE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && !rd_i |=> ($stable(ci_o) || status_o[5]));  // R2
  AST_ACK_FLAGS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> ($stable(tx_mr_o) || status_o[2]));  // R3
  AST_ABORT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_abt_o) |-> status_o[3]);  // R4
  AST_ABORT_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_abt_o) |-> $stable(rx_data_o) && $stable(tx_mr_o));  // R4
  AST_REMOTE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && rx_abt_i && !wr_i |=> status_o[1] && !tx_mx_o);  // R6
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && tx_mx_o && !frame_i |=> $stable(tx_byte_o) && tx_mx_o);  // R7
  AST_RELEASE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_mx_o) |-> status_o[0]);  // R8
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !frame_i |=> status_o == 8'h00);  // R9
  AST_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(rx_data_o) && $stable(ci_o) && $stable(tx_mr_o) && $stable(tx_abt_o));  // R10
endmodule

bind gci_mon_ep gci_mon_ep_chk #(.DATA_W(DATA_W), .CI_W(CI_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_i   (frame_i),
  .rx_abt_i  (rx_abt_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .status_o  (status_o),
  .rx_data_o (rx_data_o),
  .ci_o      (ci_o),
  .tx_byte_o (tx_byte_o),
  .tx_mx_o   (tx_mx_o),
  .tx_mr_o   (tx_mr_o),
  .tx_abt_o  (tx_abt_o)
);

// File: tb/gci_mon_ep_tb.sv
`timescale 1ns/1ps
module gci_mon_ep_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0, mx = 1'b0, mr = 1'b0, ab = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] rxb = '0, wd = '0;
  logic [3:0] ci_in = '0;
  logic [7:0] status, rx_data, tx_byte;
  logic [3:0] ci_out;
  logic       irq, tx_mx, tx_mr, tx_abt;

  int n_chk = 0, n_bad = 0;

  // bench model state
  logic [7:0] m_flags = 8'h01, m_cand = '0, m_rx = '0, m_tx = '0;
  logic [3:0] m_ci = '0;
  int         m_st = 0;  // 0 idle, 1 candidate seen, 2 skip
  logic       m_ack = 0, m_abt = 0, m_prev = 0, m_open = 0, m_full = 0, m_seen = 0;

  always #10 clk = ~clk;

  gci_mon_ep u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .rx_byte_i(rxb), .rx_mx_i(mx),
    .rx_mr_i(mr), .rx_abt_i(ab), .rx_ci_i(ci_in), .rd_i(rd), .wr_i(wr), .wdata_i(wd),
    .status_o(status), .irq_o(irq), .rx_data_o(rx_data), .ci_o(ci_out),
    .tx_byte_o(tx_byte), .tx_mx_o(tx_mx), .tx_mr_o(tx_mr), .tx_abt_o(tx_abt)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flag_bit(input int b);
    return 8'h01 << b;
  endfunction

  task automatic model_step();
    logic [7:0] set_v, clr_v;
    set_v = '0;
    clr_v = rd ? 8'hff : 8'h00;
    if (frame) begin
      if (ci_in != m_ci) begin set_v |= flag_bit(5); m_ci = ci_in; end
      m_abt = 0;
      if (!mx) begin
        if (!m_prev && m_open) begin set_v |= flag_bit(4); m_open = 0; end
        m_st = 0;
      end else if (m_st == 0) begin
        m_st = 1; m_cand = rxb;
      end else if (m_st == 1) begin
        if (rxb == m_cand) begin
          m_rx = rxb; m_ack = ~m_ack; m_open = 1; m_st = 2; set_v |= flag_bit(2);
        end else begin
          m_abt = 1; m_open = 0; m_st = 0; set_v |= flag_bit(3);
        end
      end else m_st = 0;
      m_prev = mx;
      if (ab) begin
        set_v |= flag_bit(1);
        if (m_full) begin m_full = 0; set_v |= flag_bit(0); end
      end else if (m_full && (mr != m_seen)) begin
        m_full = 0; set_v |= flag_bit(0);
      end
      m_seen = mr;
    end
    if (wr && !m_full && !(frame && set_v[0])) begin
      m_full = 1; m_tx = wd; clr_v |= 8'h01;
    end
    m_flags = (m_flags & ~clr_v) | set_v;
  endtask

  task automatic compare(input string tag);
    chk(tag, "status", status, m_flags);
    chk(tag, "irq", irq, (m_flags != 0));
    chk(tag, "rx_data", rx_data, m_rx);
    chk(tag, "ci", ci_out, m_ci);
    chk(tag, "tx_byte", tx_byte, m_tx);
    chk(tag, "tx_mx", tx_mx, m_full);
    chk(tag, "tx_mr", tx_mr, m_ack);
    chk(tag, "tx_abt", tx_abt, m_abt);
  endtask

  // one clock cycle, starting and ending at a falling edge
  task automatic cyc(input logic f, input logic [7:0] b, input logic x, input logic r,
                     input logic a, input logic [3:0] c, input logic h_rd,
                     input logic h_wr, input logic [7:0] d, input string tag);
    frame = f; rxb = b; mx = x; mr = r; ab = a; ci_in = c; rd = h_rd; wr = h_wr; wd = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    frame = 0; rd = 0; wr = 0;
    compare(tag);
  endtask

  task automatic fr(input logic [7:0] b, input logic x, input string tag);
    cyc(1, b, x, m_seen, 0, m_ci, 0, 0, 8'h00, tag);
  endtask

  task automatic host_rd(input string tag);
    cyc(0, 8'h00, 0, m_seen, 0, m_ci, 1, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");
    chk("R1", "status reset", status, 8'h01);

    // C/I change and no change
    cyc(1, 8'h00, 0, 0, 0, 4'h3, 0, 0, 8'h00, "R2 change");
    chk("R2", "cic bit", status[5], 1'b1);
    host_rd("R9 read");
    chk("R9", "cleared", status, 8'h00);
    cyc(1, 8'h00, 0, 0, 0, 4'h3, 0, 0, 8'h00, "R2 same code");
    chk("R2", "no cic", status[5], 1'b0);

    // acceptance, skip frame, second byte
    fr(8'h3C, 1, "R3 first");
    chk("R3", "not yet", status[2], 1'b0);
    fr(8'h3C, 1, "R3 accept");
    chk("R3", "rx_data", rx_data, 8'h3C);
    chk("R3", "ack toggled", tx_mr, 1'b1);
    fr(8'h3C, 1, "R3 skip");
    fr(8'h4D, 1, "R3 next first");
    fr(8'h4D, 1, "R3 next accept");
    chk("R3", "rx_data 2", rx_data, 8'h4D);
    chk("R3", "ack back", tx_mr, 1'b0);

    // end of message, then no repeat
    host_rd("R9 read");
    fr(8'h00, 0, "R5 idle1");
    chk("R5", "no eom yet", status[4], 1'b0);
    fr(8'h00, 0, "R5 idle2");
    chk("R5", "eom", status[4], 1'b1);
    host_rd("R9 read");
    fr(8'h00, 0, "R5 idle3");
    fr(8'h00, 0, "R5 idle4");
    chk("R5", "eom once", status[4], 1'b0);

    // mismatch abort
    fr(8'h11, 1, "R4 first");
    fr(8'h22, 1, "R4 mismatch");
    chk("R4", "xab", status[3], 1'b1);
    chk("R4", "abort out", tx_abt, 1'b1);
    chk("R4", "rx kept", rx_data, 8'h4D);
    host_rd("R4 abort held");
    chk("R4", "abort still out", tx_abt, 1'b1);
    fr(8'h22, 1, "R4 restart");
    chk("R4", "abort ends", tx_abt, 1'b0);
    fr(8'h00, 0, "R5 after abort1");
    fr(8'h00, 0, "R5 after abort2");
    chk("R5", "closed by abort", status[4], 1'b0);

    // transmit load, ignored write, acknowledge
    cyc(0, 8'h00, 0, m_seen, 0, m_ci, 0, 1, 8'h77, "R7 load");
    chk("R7", "tx_byte", tx_byte, 8'h77);
    chk("R7", "xmr cleared", status[0], 1'b0);
    cyc(0, 8'h00, 0, m_seen, 0, m_ci, 0, 1, 8'h88, "R7 ignored");
    chk("R7", "byte kept", tx_byte, 8'h77);
    fr(8'h00, 0, "R8 no toggle");
    chk("R8", "still pending", tx_mx, 1'b1);
    cyc(1, 8'h00, 0, ~m_seen, 0, m_ci, 0, 0, 8'h00, "R8 ack");
    chk("R8", "released", tx_mx, 1'b0);
    chk("R8", "xmr set", status[0], 1'b1);

    // remote abort drops pending byte
    cyc(0, 8'h00, 0, m_seen, 0, m_ci, 0, 1, 8'h99, "R7 load2");
    cyc(1, 8'h00, 0, m_seen, 1, m_ci, 0, 0, 8'h00, "R6 abort");
    chk("R6", "rab", status[1], 1'b1);
    chk("R6", "dropped", tx_mx, 1'b0);

    // read in the same cycle as a new flag
    host_rd("R9 read");
    cyc(1, 8'h00, 0, m_seen, 0, 4'h9, 1, 0, 8'h00, "R9 set wins");
    chk("R9", "cic survives", status, 8'h20);
    chk("R9", "irq", irq, 1'b1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic f, x, r, a, h_rd, h_wr;
      logic [7:0] b, d;
      logic [3:0] c;
      f    = ($urandom % 3) == 0;
      x    = ($urandom % 4) != 0;
      b    = ($urandom % 2) ? 8'hA5 : 8'h5A;
      r    = ($urandom % 3) == 0 ? ~m_seen : m_seen;
      a    = ($urandom % 16) == 0;
      c    = ($urandom % 4) == 0 ? 4'($urandom % 3) : m_ci;
      h_rd = ($urandom % 6) == 0;
      h_wr = ($urandom % 5) == 0;
      d    = 8'($urandom);
      cyc(f, b, x, r, a, c, h_rd, h_wr, d, "R10 random");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule